// File: doc/BRIEF.md
# Banked Stack-Pointer Control Registers

This block holds a processor's control registers. It keeps a packed status word of six flags, a condition bit, two stack pointers, and three plain 32-bit storage registers. One of these plain registers holds the backup program counter. A control read port returns the register chosen by a 3-bit selector in the same cycle. A control write port updates the chosen register on the clock edge.

General register 15 is the live stack pointer. It is physically held here, and the register file reads and writes it through a side port. The interrupt-stack register and the user-stack register each alias general register 15 or their own banked storage, depending on the stack-mode flag. When a status-word write toggles stack mode, the live pointer is saved into the bank of the mode being left. It is then reloaded from the bank of the mode being entered. The swap and the status update happen on the same edge.

Top module: `banked_sp_ctrl`

## Requirements
- R1: Selector 0 reads the status word: bit 15 backup stack mode, bit 14 backup interrupt enable, bit 8 backup condition, bit 7 stack mode, bit 6 interrupt enable, bit 0 condition. Every other bit reads 0. A write loads all six flags from the same bit positions.
- R2: Selector 1 reads the condition bit in bit 0, with zeros above it. A write to selector 1 changes only the condition bit, taken from bit 0 of the data.
- R3: With stack mode 0, selector 2 reads and writes general register 15. With stack mode 1, selector 2 reads and writes the interrupt-stack bank.
- R4: With stack mode 1, selector 3 reads and writes general register 15. With stack mode 0, selector 3 reads and writes the user-stack bank.
- R5: A status write that changes stack mode from 1 to 0 does two things on that edge. It stores the old general register 15 into the user-stack bank. It loads general register 15 from the old interrupt-stack bank.
- R6: A status write that changes stack mode from 0 to 1 does two things on that edge. It stores the old general register 15 into the interrupt-stack bank. It loads general register 15 from the old user-stack bank.
- R7: A status write that leaves stack mode unchanged moves no stack-pointer data.
- R8: Selectors 4, 5 and 6 are independent 32-bit storage registers. Selector 6 is the backup program counter.
- R9: Selector 7 reads 0, and writes to selector 7 change no register.
- R10: Every write becomes visible on both read ports in the cycle after its clock edge. The side port reads general register 15 combinationally, and a side-port write updates it on the edge.
- R11: When the control port changes general register 15 on the same edge as a side-port write, the control port wins. This covers a stack swap and a write through an aliased selector.
- R12: A synchronous active-high reset clears every flag and register to 0, so stack mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cr_rd_sel | input | 3 | Control read selector |
| cr_rd_data | output | 32 | Control read data (combinational) |
| cr_wr_en | input | 1 | Control write enable |
| cr_wr_sel | input | 3 | Control write selector |
| cr_wr_data | input | 32 | Control write data |
| sp_wr_en | input | 1 | Side-port write enable for general register 15 |
| sp_wr_data | input | 32 | Side-port write data |
| sp_rd_data | output | 32 | Current general register 15 |

## Verification
The hardest case to reach is a swap that happens while all three stack-pointer storage places hold distinct, known values and a side-port write is also pending. Seeding these values is not simple. The bank visible through each selector depends on the current mode, so the bench must fill them in two steps. It writes the banked copies through the non-aliased selector in each mode, and it fills the live pointer through the side port. It then issues status writes that toggle, keep, and re-toggle the mode, sometimes with a side-port write in the same cycle. After every operation the bench sweeps all eight selectors and compares them against a model driven by the requirements.

// File: rtl/banked_sp_pkg.sv
package banked_sp_pkg;

    localparam int DATA_W = 32;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 3'd0,
        SEL_COND   = 3'd1,
        SEL_SP_INT = 3'd2,
        SEL_SP_USR = 3'd3,
        SEL_AUX0   = 3'd4,
        SEL_AUX1   = 3'd5,
        SEL_BPC    = 3'd6,
        SEL_NONE   = 3'd7
    } ctl_sel_e;

    // Bit positions inside the packed status word
    localparam int POS_BSM   = 15;
    localparam int POS_BIE   = 14;
    localparam int POS_BCOND = 8;
    localparam int POS_SM    = 7;
    localparam int POS_IE    = 6;
    localparam int POS_COND  = 0;

    typedef struct packed {
        logic bsm;
        logic bie;
        logic bcond;
        logic sm;
        logic ie;
        logic cond;
    } status_t;

    function automatic logic [DATA_W-1:0] pack_status(status_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[POS_BSM]   = s.bsm;
        w[POS_BIE]   = s.bie;
        w[POS_BCOND] = s.bcond;
        w[POS_SM]    = s.sm;
        w[POS_IE]    = s.ie;
        w[POS_COND]  = s.cond;
        return w;
    endfunction

    function automatic status_t unpack_status(logic [DATA_W-1:0] w);
        status_t s;
        s.bsm   = w[POS_BSM];
        s.bie   = w[POS_BIE];
        s.bcond = w[POS_BCOND];
        s.sm    = w[POS_SM];
        s.ie    = w[POS_IE];
        s.cond  = w[POS_COND];
        return s;
    endfunction

    localparam logic [DATA_W-1:0] STATUS_MASK =
        (DATA_W'(1) << POS_BSM) | (DATA_W'(1) << POS_BIE) | (DATA_W'(1) << POS_BCOND) |
        (DATA_W'(1) << POS_SM)  | (DATA_W'(1) << POS_IE)  | (DATA_W'(1) << POS_COND);

endpackage

// File: rtl/bsp_status.sv
module bsp_status
    import banked_sp_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_status,
    input  logic          wr_cond,
    input  logic [DW-1:0] wr_data,
    output status_t       st,
    output logic          swap_up,
    output logic          swap_down
);

    status_t incoming;

    always_comb begin
        incoming  = unpack_status(wr_data);
        swap_up   = wr_status && !st.sm && incoming.sm;
        swap_down = wr_status && st.sm && !incoming.sm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (wr_status) begin
            st <= incoming;
        end else if (wr_cond) begin
            st.cond <= wr_data[0];
        end
    end

    // R2: a write to the condition selector touches no other flag
    assert_cond_only_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_cond && !wr_status) |=> (st.sm == $past(st.sm) && st.ie == $past(st.ie)
                                     && st.bsm == $past(st.bsm)));

    // swap directions never both asserted
    assert_swap_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(swap_up && swap_down));

endmodule

// File: rtl/bsp_stack_bank.sv
module bsp_stack_bank
    import banked_sp_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sm,
    input  logic          swap_up,
    input  logic          swap_down,
    input  logic          wr_int,
    input  logic          wr_usr,
    input  logic [DW-1:0] wr_data,
    input  logic          side_we,
    input  logic [DW-1:0] side_wd,
    output logic [DW-1:0] gr15,
    output logic [DW-1:0] int_rd,
    output logic [DW-1:0] usr_rd
);

    logic [DW-1:0] bank_int;
    logic [DW-1:0] bank_usr;
    logic          ctl_hits_gr;

    always_comb begin
        ctl_hits_gr = (wr_int && !sm) || (wr_usr && sm);
        int_rd      = sm ? bank_int : gr15;
        usr_rd      = sm ? gr15 : bank_usr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gr15     <= '0;
            bank_int <= '0;
            bank_usr <= '0;
        end else if (swap_up) begin
            bank_int <= gr15;
            gr15     <= bank_usr;
        end else if (swap_down) begin
            bank_usr <= gr15;
            gr15     <= bank_int;
        end else begin
            if (wr_int && sm)  bank_int <= wr_data;
            if (wr_usr && !sm) bank_usr <= wr_data;
            if (ctl_hits_gr)   gr15 <= wr_data;
            else if (side_we)  gr15 <= side_wd;
        end
    end

    assert_swap_down_R5: assert property (@(posedge clk) disable iff (rst)
        swap_down |=> (bank_usr == $past(gr15) && gr15 == $past(bank_int)));

    assert_swap_up_R6: assert property (@(posedge clk) disable iff (rst)
        swap_up |=> (bank_int == $past(gr15) && gr15 == $past(bank_usr)));

    assert_banks_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!swap_up && !swap_down && !wr_int && !wr_usr) |=> ($stable(bank_int) && $stable(bank_usr)));

    assert_ctl_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (ctl_hits_gr && !swap_up && !swap_down) |=> gr15 == $past(wr_data));

endmodule

// File: rtl/bsp_aux_store.sv
module bsp_aux_store
    import banked_sp_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int SW    = SEL_W,
    parameter int BASE  = 4,
    parameter int COUNT = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [SW-1:0] rd_sel,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] regs [COUNT];
    logic [DW-1:0] hits [COUNT];

    for (genvar i = 0; i < COUNT; i++) begin : g_reg
        localparam logic [SW-1:0] MY_SEL = SW'(BASE + i);
        always_ff @(posedge clk) begin
            if (rst)                              regs[i] <= '0;
            else if (wr_en && wr_sel == MY_SEL)   regs[i] <= wr_data;
        end
        assign hits[i] = (rd_sel == MY_SEL) ? regs[i] : '0;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < COUNT; i++) rd_data = rd_data | hits[i];
    end

endmodule

// File: rtl/banked_sp_ctrl.sv
module banked_sp_ctrl
    import banked_sp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  cr_rd_sel,
    output logic [DATA_W-1:0] cr_rd_data,
    input  logic              cr_wr_en,
    input  logic [SEL_W-1:0]  cr_wr_sel,
    input  logic [DATA_W-1:0] cr_wr_data,
    input  logic              sp_wr_en,
    input  logic [DATA_W-1:0] sp_wr_data,
    output logic [DATA_W-1:0] sp_rd_data
);

    status_t           st;
    logic              swap_up, swap_down;
    logic [DATA_W-1:0] int_rd, usr_rd, aux_rd;

    bsp_status #(.DW(DATA_W)) u_status (
        .clk       (clk),
        .rst       (rst),
        .wr_status (cr_wr_en && cr_wr_sel == SEL_STATUS),
        .wr_cond   (cr_wr_en && cr_wr_sel == SEL_COND),
        .wr_data   (cr_wr_data),
        .st        (st),
        .swap_up   (swap_up),
        .swap_down (swap_down)
    );

    bsp_stack_bank #(.DW(DATA_W)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .sm        (st.sm),
        .swap_up   (swap_up),
        .swap_down (swap_down),
        .wr_int    (cr_wr_en && cr_wr_sel == SEL_SP_INT),
        .wr_usr    (cr_wr_en && cr_wr_sel == SEL_SP_USR),
        .wr_data   (cr_wr_data),
        .side_we   (sp_wr_en),
        .side_wd   (sp_wr_data),
        .gr15      (sp_rd_data),
        .int_rd    (int_rd),
        .usr_rd    (usr_rd)
    );

    bsp_aux_store #(.DW(DATA_W), .SW(SEL_W), .BASE(4), .COUNT(3)) u_aux (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cr_wr_en),
        .wr_sel  (cr_wr_sel),
        .wr_data (cr_wr_data),
        .rd_sel  (cr_rd_sel),
        .rd_data (aux_rd)
    );

    always_comb begin
        unique case (cr_rd_sel)
            SEL_STATUS: cr_rd_data = pack_status(st);
            SEL_COND:   cr_rd_data = {{(DATA_W-1){1'b0}}, st.cond};
            SEL_SP_INT: cr_rd_data = int_rd;
            SEL_SP_USR: cr_rd_data = usr_rd;
            SEL_AUX0, SEL_AUX1, SEL_BPC: cr_rd_data = aux_rd;
            default:    cr_rd_data = '0;
        endcase
    end

    assert_status_reserved_R1: assert property (@(posedge clk) disable iff (rst)
        (cr_rd_sel == SEL_STATUS) |-> ((cr_rd_data & ~STATUS_MASK) == '0));

    assert_cond_upper_R2: assert property (@(posedge clk) disable iff (rst)
        (cr_rd_sel == SEL_COND) |-> (cr_rd_data[DATA_W-1:1] == '0));

    assert_sel7_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (cr_rd_sel == SEL_NONE) |-> (cr_rd_data == '0));

    assert_alias_R3: assert property (@(posedge clk) disable iff (rst)
        (cr_rd_sel == SEL_SP_INT && !st.sm) |-> (cr_rd_data == sp_rd_data));

    assert_alias_R4: assert property (@(posedge clk) disable iff (rst)
        (cr_rd_sel == SEL_SP_USR && st.sm) |-> (cr_rd_data == sp_rd_data));

    assert_reset_clear_R12: assert property (@(posedge clk)
        rst |=> (sp_rd_data == '0));

endmodule

// File: tb/tb_banked_sp_ctrl.sv
module tb_banked_sp_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst;
    logic [2:0]  cr_rd_sel;
    logic [31:0] cr_rd_data;
    logic        cr_wr_en;
    logic [2:0]  cr_wr_sel;
    logic [31:0] cr_wr_data;
    logic        sp_wr_en;
    logic [31:0] sp_wr_data;
    logic [31:0] sp_rd_data;

    int n_checks = 0;
    int n_fail   = 0;

    // model state
    logic        m_bsm, m_bie, m_bcond, m_sm, m_ie, m_cond;
    logic [31:0] m_gr, m_bint, m_busr;
    logic [31:0] m_aux [4:6];

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_sp_ctrl dut (
        .clk(clk), .rst(rst),
        .cr_rd_sel(cr_rd_sel), .cr_rd_data(cr_rd_data),
        .cr_wr_en(cr_wr_en), .cr_wr_sel(cr_wr_sel), .cr_wr_data(cr_wr_data),
        .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .sp_rd_data(sp_rd_data)
    );

    function automatic logic [31:0] exp_read(int sel);
        case (sel)
            0: return (32'(m_bsm) << 15) | (32'(m_bie) << 14) | (32'(m_bcond) << 8)
                    | (32'(m_sm) << 7) | (32'(m_ie) << 6) | 32'(m_cond);
            1: return 32'(m_cond);
            2: return m_sm ? m_bint : m_gr;
            3: return m_sm ? m_gr : m_busr;
            4, 5, 6: return m_aux[sel];
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic sweep(string tag);
        for (int s = 0; s < 8; s++) begin
            cr_rd_sel = 3'(s);
            #1;
            check(tag, $sformatf("sel %0d", s), cr_rd_data, exp_read(s));
        end
        check(tag, "gr15 side port", sp_rd_data, m_gr);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // control write, optionally with a simultaneous side-port write
    task automatic op(int sel, logic [31:0] d, logic side, logic [31:0] sd);
        logic touches;
        logic [31:0] g0;
        g0 = m_gr;
        touches = 0;
        case (sel)
            0: begin
                if (d[7] != m_sm) begin
                    touches = 1;
                    if (m_sm) begin m_busr = g0; m_gr = m_bint; end
                    else      begin m_bint = g0; m_gr = m_busr; end
                end
                m_bsm = d[15]; m_bie = d[14]; m_bcond = d[8];
                m_sm = d[7]; m_ie = d[6]; m_cond = d[0];
            end
            1: m_cond = d[0];
            2: if (m_sm) m_bint = d; else begin m_gr = d; touches = 1; end
            3: if (m_sm) begin m_gr = d; touches = 1; end else m_busr = d;
            4, 5, 6: m_aux[sel] = d;
            default: ;
        endcase
        if (side && !touches) m_gr = sd;
        cr_wr_en = 1; cr_wr_sel = 3'(sel); cr_wr_data = d;
        sp_wr_en = side; sp_wr_data = sd;
        tick();
        cr_wr_en = 0; sp_wr_en = 0;
    endtask

    task automatic side_only(logic [31:0] sd);
        m_gr = sd;
        sp_wr_en = 1; sp_wr_data = sd;
        tick();
        sp_wr_en = 0;
    endtask

    task automatic model_reset();
        {m_bsm, m_bie, m_bcond, m_sm, m_ie, m_cond} = '0;
        m_gr = 0; m_bint = 0; m_busr = 0;
        for (int i = 4; i <= 6; i++) m_aux[i] = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        cr_rd_sel = 0; cr_wr_en = 0; cr_wr_sel = 0; cr_wr_data = 0;
        sp_wr_en = 0; sp_wr_data = 0;
        rst = 1;
        // dirty state first, then reset to prove clearing
        @(negedge clk); @(negedge clk);
        rst = 0;
        op(4, 32'hDEAD_0004, 0, 0);
        side_only(32'h1234_5678);
        rst = 1; tick(); rst = 0;
        model_reset();
        sweep("R12");

        // R1: every status bit pattern on the six flag positions plus junk elsewhere
        for (int p = 0; p < 64; p++) begin
            logic [31:0] d;
            d = 32'hFFFF_FFFF & ~((32'h1 << 15) | (32'h1 << 14) | (32'h1 << 8)
                                 | (32'h1 << 7) | (32'h1 << 6) | 32'h1);
            d = d | (32'(p[5]) << 15) | (32'(p[4]) << 14) | (32'(p[3]) << 8)
                  | (32'(p[2]) << 7) | (32'(p[1]) << 6) | 32'(p[0]);
            op(0, d, 0, 0);
            sweep("R1");
        end
        op(0, 32'h0, 0, 0);

        // R2: condition selector
        op(1, 32'hFFFF_FFFE, 0, 0); sweep("R2");
        op(0, 32'h0000_C141 & ~32'h80, 0, 0);
        op(1, 32'h0000_0001, 0, 0); sweep("R2");
        op(1, 32'h0000_0000, 0, 0); sweep("R2");

        // R3/R4 in mode 0, side-port R10
        op(0, 32'h0, 0, 0);
        side_only(32'hA000_0001); sweep("R10");
        op(2, 32'hA000_0002, 0, 0); sweep("R3");
        op(3, 32'hB000_0003, 0, 0); sweep("R4");
        // R6: 0 -> 1
        op(0, 32'h0000_0080, 0, 0); sweep("R6");
        op(2, 32'hC000_0004, 0, 0); sweep("R3");
        op(3, 32'hC000_0005, 0, 0); sweep("R4");
        // R7: status writes keeping mode 1
        op(0, 32'h0000_C1C1, 0, 0); sweep("R7");
        op(0, 32'h0000_0080, 1, 32'hE000_0006); sweep("R7");
        // R5: 1 -> 0
        op(0, 32'h0000_0000, 0, 0); sweep("R5");
        op(0, 32'h0000_0000, 0, 0); sweep("R7");
        // R11: swaps with concurrent side writes
        op(0, 32'h0000_0080, 1, 32'hF000_0007); sweep("R11");
        op(0, 32'h0000_0000, 1, 32'hF000_0008); sweep("R11");
        op(2, 32'h1111_0009, 1, 32'hF000_000A); sweep("R11");
        op(3, 32'h2222_000B, 1, 32'hF000_000C); sweep("R11");
        op(0, 32'h0000_0080, 0, 0);
        op(3, 32'h3333_000D, 1, 32'hF000_000E); sweep("R11");
        op(2, 32'h4444_000F, 1, 32'hF000_0010); sweep("R11");

        // R8: plain storage
        for (int s = 4; s <= 6; s++) begin
            op(s, 32'h5A5A_0000 + 32'(s), 0, 0); sweep("R8");
        end
        op(6, 32'h0BAD_F00D, 0, 0); sweep("R8");

        // R9: writes to selector 7 ignored
        op(7, 32'hFFFF_FFFF, 0, 0); sweep("R9");
        op(7, 32'h0000_0000, 0, 0); sweep("R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule